// File: doc/BRIEF.md
# Memory-Mapped Serial Transceiver

This block is a minimal asynchronous serial transceiver driven from a synchronous 8-bit processor bus. The bus has two locations. Location 0 is the data port. Writing it hands a byte to the transmitter, and reading it returns the most recently received byte. Location 1 is a read-only status word.

Frames use one low start bit, then eight data bits with the least significant bit first, then one high stop bit. Every bit lasts `CLKS_PER_BIT` system clocks. The serial input is re-timed through a flip-flop chain before the receiver uses it. The receiver samples each bit at its midpoint, measured from the detected falling edge of the start bit.

The three status flags have no storage of their own. They are decoded from the transmit state register and from the receive state register. The receive state register includes a small field that records whether it holds no byte, a good byte or a byte with a bad stop bit.

Top module: `uart_mmio`

## Requirements
- R1: After reset, `ser_out` is 1, `bus_rdata` is 0x00, and a status read returns 0x04.
- R2: A write to address 0 while the transmitter is idle sends a frame on `ser_out`. The frame is one start bit at 0, then the byte LSB first, then one stop bit at 1. Each bit is `CLKS_PER_BIT` clocks long, and the start bit begins on the clock edge that samples the write.
- R3: Status bit 2 (transmitter ready) is 1 only while the transmitter is idle. It is 0 from the edge that accepts a write until the stop bit has ended, and it is 1 again after that.
- R4: A write to address 0 while status bit 2 is 0 is ignored. The frame in progress is unchanged, and no second frame follows it.
- R5: A frame received on `ser_in` with a stop bit of 1 sets status bit 0 (byte ready) and leaves bit 1 at 0. A read of address 0 then returns the received byte.
- R6: A received frame whose stop bit is sampled as 0 sets status bit 1 (receive error) and leaves status bit 0 at 0. Bits 0 and 1 are never both 1.
- R7: A read of address 0 clears status bits 0 and 1. If a second frame arrives before any read, it replaces the first, and a read returns the second byte.
- R8: A low pulse on `ser_in` that has returned to 1 by the midpoint of the start bit is discarded. The flags and the held byte stay as they were, and the receiver accepts the next frame normally.
- R9: `bus_rdata` is registered. It changes only on the edge that samples `bus_rd`, and it holds its value otherwise. In a status read, bits 7 to 3 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 1 | Location select: 0 data, 1 status |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ser_in | input | 1 | Asynchronous serial input |
| ser_out | output | 1 | Serial output, idles high |

## Verification
The bound checker watches several cycle-level relations on every cycle. The serial output must drop on the edge where the transmitter leaves idle. A write that arrives while the transmitter is busy must leave its held byte unchanged. The read-data register must hold still whenever no read occurs, and the upper status bits must read as zero. The two receive flags must never be set together, and a data read must clear both flags. Other behaviours need whole serial frames, so only the bench scenarios can show them: the bit order and bit length on the wire, mid-bit sampling of a driven frame, the stop-bit error, replacement of an unread byte, and rejection of a short start pulse.

// File: rtl/uart_pkg.sv
// Shared types and constants for the serial transceiver.
// Assumes an 8-bit bus and frames of 8 data bits.
package uart_pkg;
    localparam int DATA_BITS = 8;
    localparam int IDX_W     = $clog2(DATA_BITS);

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

    // Bit positions inside the status word
    localparam int ST_RX_READY = 0;
    localparam int ST_RX_ERROR = 1;
    localparam int ST_TX_READY = 2;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_phase_t;
    typedef enum logic [1:0] {HOLD_EMPTY, HOLD_GOOD, HOLD_BAD} rx_hold_t;
endpackage

// File: rtl/uart_retime.sv
// Re-times an asynchronous input through STAGES flip-flops.
// Assumes the input idles at RESET_VAL.
module uart_retime #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flip-flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_tx_engine.sv
// Transmit state machine: serialises one byte per accepted load.
// A load is taken only in idle; ready is decoded from the state.
module uart_tx_engine
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    output logic                 ready,
    output logic                 ser_out,
    output logic [DATA_BITS-1:0] held_byte
);
    localparam int          CW   = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_BITS - 1);

    tx_state_t            state;
    logic [CW-1:0]        cnt;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] data_q;

    // Advance through start, data and stop bits on bit-time boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            data_q <= '0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (load) begin
                        data_q <= load_data;
                        cnt    <= '0;
                        state  <= TX_START;
                    end
                end
                TX_START: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= TX_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                TX_DATA: begin
                    if (cnt == LAST) begin
                        cnt <= '0;
                        if (idx == TOP_IDX) state <= TX_STOP;
                        else                idx   <= idx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        state <= TX_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Line level decoded from the state and the bit index
    always_comb begin
        case (state)
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = data_q[idx];
            default:  ser_out = 1'b1;
        endcase
    end

    assign ready     = (state == TX_IDLE);
    assign held_byte = data_q;
endmodule

// File: rtl/uart_rx_engine.sv
// Receive state machine: finds a start edge, samples at bit midpoints,
// and records the outcome in the hold field of its state.
// Assumes a re-timed input. A clear and a completion in the same cycle
// resolve to the completion.
module uart_rx_engine
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_in,
    input  logic                 clear,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_ready,
    output logic                 rx_error,
    output logic                 frame_end
);
    localparam int          CW        = $clog2(CLKS_PER_BIT);
    localparam logic [CW-1:0] LAST      = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] HALF_LAST = CW'(CLKS_PER_BIT / 2 - 1);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DATA_BITS - 1);

    rx_phase_t            phase;
    rx_hold_t             hold;
    logic [CW-1:0]        cnt;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] shift_q;
    logic [DATA_BITS-1:0] byte_q;

    // Sequence the receive phases and update the hold field
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= RX_IDLE;
            hold    <= HOLD_EMPTY;
            cnt     <= '0;
            idx     <= '0;
            shift_q <= '0;
            byte_q  <= '0;
        end else begin
            if (clear) hold <= HOLD_EMPTY;
            case (phase)
                RX_IDLE: begin
                    if (!rx_in) begin
                        cnt   <= '0;
                        phase <= RX_START;
                    end
                end
                RX_START: begin
                    if (cnt == HALF_LAST) begin
                        cnt   <= '0;
                        idx   <= '0;
                        phase <= rx_in ? RX_IDLE : RX_DATA;
                    end else cnt <= cnt + 1'b1;
                end
                RX_DATA: begin
                    if (cnt == LAST) begin
                        cnt     <= '0;
                        shift_q <= {rx_in, shift_q[DATA_BITS-1:1]};
                        if (idx == TOP_IDX) phase <= RX_STOP;
                        else                idx   <= idx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    if (cnt == LAST) begin
                        cnt    <= '0;
                        byte_q <= shift_q;
                        hold   <= rx_in ? HOLD_GOOD : HOLD_BAD;
                        phase  <= RX_IDLE;
                    end else cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    assign rx_byte   = byte_q;
    assign rx_ready  = (hold == HOLD_GOOD);
    assign rx_error  = (hold == HOLD_BAD);
    assign frame_end = (phase == RX_STOP) && (cnt == LAST);
endmodule

// File: rtl/uart_mmio.sv
// Top level: two-location bus front end over the transmit and receive
// engines. Status flags come straight from the engine state decodes.
// Assumes single-cycle bus strobes and CLKS_PER_BIT of at least 4.
module uart_mmio
    import uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ser_in,
    output logic       ser_out
);
    logic                 rx_sync;
    logic                 tx_ready, rx_ready, rx_error, frame_end;
    logic [DATA_BITS-1:0] rx_byte, tx_held;
    logic [7:0]           status_word;
    logic                 tx_load, rx_clear;

    assign tx_load  = bus_wr && (bus_addr == ADDR_DATA);
    assign rx_clear = bus_rd && (bus_addr == ADDR_DATA);

    uart_retime #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(ser_in), .dout(rx_sync)
    );

    uart_tx_engine #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(bus_wdata),
        .ready(tx_ready), .ser_out(ser_out), .held_byte(tx_held)
    );

    uart_rx_engine #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_sync), .clear(rx_clear),
        .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_error(rx_error),
        .frame_end(frame_end)
    );

    // Assemble the status word from the engine decodes
    always_comb begin
        status_word              = '0;
        status_word[ST_TX_READY] = tx_ready;
        status_word[ST_RX_ERROR] = rx_error;
        status_word[ST_RX_READY] = rx_ready;
    end

    // Register read data on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= (bus_addr == ADDR_STAT) ? status_word : rx_byte;
    end
endmodule

// File: rtl/uart_mmio_chk.sv
// Checker for uart_mmio, attached by bind. Observes ports and engine outputs.
module uart_mmio_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       ser_out,
    input logic       tx_ready,
    input logic       rx_ready,
    input logic       rx_error,
    input logic       frame_end,
    input logic [7:0] tx_held
);
    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> !ser_out);

    // R3
    busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && tx_ready) |=> !tx_ready);

    // R4
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && !tx_ready) |=> $stable(tx_held));

    // R6
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ready, rx_error}));

    // R7
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr && !frame_end) |=> (!rx_ready && !rx_error));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R9
    status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr) |=> (bus_rdata[7:3] == 5'b0));
endmodule

bind uart_mmio uart_mmio_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ser_out(ser_out),
    .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_error(rx_error),
    .frame_end(frame_end), .tx_held(tx_held)
);

// File: tb/uart_mmio_test.sv
module uart_mmio_test;
    localparam int CLK_PERIOD = 10;
    localparam int C = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ser_in = 1'b1;
    logic       ser_out;
    int checks = 0, fails = 0;

    uart_mmio #(.CLKS_PER_BIT(C)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send_frame(input logic [7:0] b, input logic stop);
        logic [9:0] bits;
        bits = {stop, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            ser_in = bits[i];
            repeat (C) @(negedge clk);
        end
        ser_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [7:0] s;
        check("R1 ser_out", {7'b0, ser_out}, 8'h01);
        check("R1 rdata", bus_rdata, 8'h00);
        bus_read(1'b1, s);
        check("R1 status", s, 8'h04);
    endtask

    task automatic test_tx(input logic [7:0] b, input bit bump);
        logic [7:0] s;
        bus_write(1'b0, b);
        repeat (C/2 - 1) @(negedge clk);
        bus_read(1'b1, s);
        check("R3 busy status", s, 8'h00);
        check("R2 start bit", {7'b0, ser_out}, 8'h00);
        for (int i = 0; i < 8; i++) begin
            if (bump && i == 3) begin
                repeat (C - 1) @(negedge clk);
                bus_write(1'b0, ~b);
            end else repeat (C) @(negedge clk);
            check(bump ? "R4 data bit" : "R2 data bit", {7'b0, ser_out}, {7'b0, b[i]});
        end
        repeat (C) @(negedge clk);
        check("R2 stop bit", {7'b0, ser_out}, 8'h01);
        repeat (C) @(negedge clk);
        bus_read(1'b1, s);
        check("R3 idle status", s, 8'h04);
        if (bump) begin
            repeat (2*C) @(negedge clk);
            check("R4 no second frame", {7'b0, ser_out}, 8'h01);
        end
    endtask

    task automatic test_rx_good(input logic [7:0] b);
        logic [7:0] s;
        send_frame(b, 1'b1);
        bus_read(1'b1, s);
        check("R5 ready status", s, 8'h05);
        bus_read(1'b0, s);
        check("R5 byte", s, b);
        bus_read(1'b1, s);
        check("R7 cleared", s, 8'h04);
    endtask

    task automatic test_rx_bad();
        logic [7:0] s;
        send_frame(8'h3C, 1'b0);
        bus_read(1'b1, s);
        check("R6 error status", s, 8'h06);
        bus_read(1'b0, s);
        bus_read(1'b1, s);
        check("R7 error cleared", s, 8'h04);
    endtask

    task automatic test_overwrite();
        logic [7:0] s;
        send_frame(8'h11, 1'b1);
        send_frame(8'hE7, 1'b1);
        bus_read(1'b0, s);
        check("R7 newer byte", s, 8'hE7);
        bus_read(1'b1, s);
        check("R7 flags clear", s, 8'h04);
    endtask

    task automatic test_glitch();
        logic [7:0] s;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        ser_in = 1'b1;
        repeat (2*C) @(negedge clk);
        bus_read(1'b1, s);
        check("R8 no flag", s, 8'h04);
        bus_read(1'b0, s);
        check("R8 byte kept", s, 8'hE7);
        test_rx_good(8'h96);
    endtask

    task automatic test_rdata_hold();
        logic [7:0] s;
        bus_read(1'b1, s);
        bus_wr = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 rdata held", bus_rdata, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_tx(8'hA5, 1'b0);
        test_tx(8'h01, 1'b0);
        test_tx(8'h5A, 1'b1);
        test_rx_good(8'hC3);
        test_rx_good(8'h80);
        test_rx_bad();
        test_overwrite();
        test_glitch();
        test_rdata_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule